// File: doc/BRIEF.md
# Dual-Mode Serial Host Port

This block is the slave end of a byte link to a host processor. Four shared pins carry the traffic. A strap on the clock/select pin, read once as reset is released, picks the mode. With the strap high the port is a synchronous slave. Its serial clock idles high, bits go out most significant first, and a slave-driven active-low attention line means the slave has data or is ready to take data. With the strap low the same pins form a fixed-rate asynchronous serial port with request/clear-to-send flow control. The rate is one bit per 64 system clocks, which is 62.5 kbit/s at a 4 MHz system clock.

The internal side sees a one-byte transmit holding register with a valid/ready handshake. It also sees a one-cycle receive strobe with the byte, a framing-error flag and a ready level. The ready level says whether the internal logic can take host data. Every host pin is brought into the system clock domain through synchronizers. Serial clock edges are found in that domain, so the serial clock must run well below the system clock. At 4 MHz this allows 500 kbit/s. A falling edge on the select/request line gives a one-cycle wake pulse. The port does not interpret bytes and does not frame packets.

Top module: `hostlink_port`

## Requirements
- R1: In the first clock after reset is released, `sclk_isel` is sampled: 1 gives `spi_mode`=1 (synchronous mode), 0 gives `spi_mode`=0 (asynchronous mode). Later changes of the pin do not change the mode.
- R2: After reset with the host idle and nothing loaded, `tx_ready`=1, `rx_valid`=0 and `atn_cts_n`=1. `miso_txd`=1 in asynchronous mode.
- R3: An asynchronous transmit frame is one low start bit, then 8 data bits with bit 0 first, then one high stop bit. Each bit lasts CLKS_PER_BIT clocks (64 by default). The line is high between frames.
- R4: An asynchronous frame starts only while `ss_rts_n` is low. While it is high, a loaded byte stays held, `tx_ready` stays 0 and the line stays high.
- R5: The asynchronous receiver finds the start bit and samples each bit near its middle. At the stop bit it pulses `rx_valid` for one cycle with the byte (bit 0 first on the line) on `rx_data`.
- R6: If the received stop bit is low, `rx_frame_err`=1 in the same cycle as `rx_valid`. It is 0 otherwise.
- R7: In asynchronous mode `atn_cts_n` is low exactly when `rx_ready` is high.
- R8: In synchronous mode the clock idles high. The slave drives `miso_txd` after each falling edge and captures `mosi_rxd` on each rising edge, most significant bit first. After 8 rising edges it pulses `rx_valid` with the host byte, and the host has received the loaded byte. Further bytes follow within one select without a gap.
- R9: In synchronous mode `atn_cts_n` is low while a byte is held, while `rx_ready` is high, or while an exchange is under way with select low. Otherwise it is high.
- R10: In synchronous mode, clock edges that arrive while select is low and attention is high are ignored: no `rx_valid` results and attention stays high.
- R11: `miso_oe` is 1 in synchronous mode only while `ss_rts_n` is low. It is always 1 in asynchronous mode.
- R12: Every falling edge of `ss_rts_n` gives exactly one one-cycle `wake` pulse, in either mode.
- R13: If a synchronous exchange starts, or a further byte begins, with no byte held, the slave sends 0x00.
- R14: A byte is accepted when `tx_valid` and `tx_ready` are both 1. `tx_ready` is then 0 until that byte is taken into a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_isel | input | 1 | Serial clock in synchronous mode; mode strap at reset release |
| mosi_rxd | input | 1 | Host data in (synchronous) or receive line (asynchronous) |
| ss_rts_n | input | 1 | Active-low host select or request-to-send |
| miso_txd | output | 1 | Slave data out or transmit line |
| miso_oe | output | 1 | Output enable for miso_txd |
| atn_cts_n | output | 1 | Active-low attention or clear-to-send |
| spi_mode | output | 1 | Latched mode, 1 = synchronous |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Holding register is empty |
| rx_ready | input | 1 | Internal logic can take host data |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_frame_err | output | 1 | Stop bit was low (asynchronous mode) |
| wake | output | 1 | One-cycle pulse on select/request falling edge |

## Verification
In synchronous mode, fixed byte pairs and seeded random byte pairs are exchanged in both directions. This separates bit order and edge choice from data corruption. A two-byte burst checks that the second byte reloads inside one select. An exchange with nothing held shows the zero fill. An exchange with attention high shows that clock edges are ignored. In asynchronous mode, random bytes pass through the transmitter and the receiver and are decoded by bit timing alone, so errors in bit width or bit order show up. A low stop bit separates framing-error reporting from normal reception. Holding request high shows that transmit waits for flow control. A second reset with the other strap value, followed by toggling the strap pin, tests the mode latch.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WAIT_HIGH
   } rx_state_t;
endpackage

// File: rtl/hl_sync.sv
module hl_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hl_sync needs at least two stages");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/hl_spi_slave.sv
module hl_spi_slave
   import hostlink_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sclk_s,
   input  logic              mosi_s,
   input  logic              ss_s,
   input  logic              hold_full,
   input  logic [BYTE_W-1:0] hold_data,
   input  logic              rx_ready,
   output logic              take,
   output logic              miso,
   output logic              active,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_data
);
   localparam int BIT_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] tx_sh;
   logic [BYTE_W-1:0] rx_sh;
   logic [BIT_W-1:0]  bitn;
   logic              sclk_d;
   logic              fall, rise, last_bit, start_ok, reload;

   assign fall     = sclk_d & ~sclk_s;
   assign rise     = ~sclk_d & sclk_s;
   assign last_bit = (bitn == BIT_W'(BYTE_W - 1));
   assign start_ok = en & ~ss_s & ~active & (hold_full | rx_ready);
   assign reload   = en & ~ss_s & active & rise & last_bit;
   assign take     = hold_full & (start_ok | reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b1;
         active   <= 1'b0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         bitn     <= '0;
         miso     <= 1'b1;
         rx_valid <= 1'b0;
         rx_data  <= '0;
      end else begin
         sclk_d   <= sclk_s;
         rx_valid <= 1'b0;
         if (!en || ss_s) begin
            active <= 1'b0;
            bitn   <= '0;
         end else if (!active) begin
            if (start_ok) begin
               active <= 1'b1;
               bitn   <= '0;
               tx_sh  <= hold_full ? hold_data : '0;
            end
         end else begin
            if (fall) begin
               miso  <= tx_sh[BYTE_W-1];
               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
            if (rise) begin
               rx_sh <= {rx_sh[BYTE_W-2:0], mosi_s};
               bitn  <= bitn + BIT_W'(1);
               if (last_bit) begin
                  rx_valid <= 1'b1;
                  rx_data  <= {rx_sh[BYTE_W-2:0], mosi_s};
                  tx_sh    <= hold_full ? hold_data : '0;
                  bitn     <= '0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/hl_uart_tx.sv
module hl_uart_tx
   import hostlink_pkg::*;
#(
   parameter int CLKS_PER_BIT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  logic [BYTE_W-1:0] data,
   output logic              txd,
   output logic              busy
);
   localparam int FRAME_BITS = BYTE_W + 2;
   localparam int FB_W       = $clog2(FRAME_BITS);
   localparam int CNT_W      = $clog2(CLKS_PER_BIT);

   logic [FRAME_BITS-1:0] frame;
   logic [FB_W-1:0]       bitn;
   logic [CNT_W-1:0]      cnt;

   assign txd = frame[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame <= '1;
         busy  <= 1'b0;
         bitn  <= '0;
         cnt   <= '0;
      end else if (!en) begin
         frame <= '1;
         busy  <= 1'b0;
         bitn  <= '0;
         cnt   <= '0;
      end else if (!busy) begin
         if (start) begin
            frame <= {1'b1, data, 1'b0};
            busy  <= 1'b1;
            bitn  <= '0;
            cnt   <= '0;
         end
      end else if (cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
         cnt   <= '0;
         frame <= {1'b1, frame[FRAME_BITS-1:1]};
         if (bitn == FB_W'(FRAME_BITS - 1)) busy <= 1'b0;
         else                               bitn <= bitn + FB_W'(1);
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/hl_uart_rx.sv
module hl_uart_rx
   import hostlink_pkg::*;
#(
   parameter int CLKS_PER_BIT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rxd_s,
   output logic              rx_valid,
   output logic              frame_err,
   output logic [BYTE_W-1:0] rx_data
);
   localparam int CNT_W = $clog2(CLKS_PER_BIT);
   localparam int BIT_W = $clog2(BYTE_W);
   localparam int HALF  = CLKS_PER_BIT / 2;

   rx_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [BYTE_W-1:0] sh;
   logic              bit_end;

   assign bit_end = (cnt == CNT_W'(CLKS_PER_BIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         cnt       <= '0;
         bitn      <= '0;
         sh        <= '0;
         rx_valid  <= 1'b0;
         frame_err <= 1'b0;
         rx_data   <= '0;
      end else begin
         rx_valid  <= 1'b0;
         frame_err <= 1'b0;
         if (!en) begin
            state <= RX_IDLE;
            cnt   <= '0;
         end else begin
            case (state)
               RX_IDLE: begin
                  cnt <= '0;
                  if (!rxd_s) state <= RX_START;
               end
               RX_START: begin
                  if (cnt == CNT_W'(HALF - 1)) begin
                     cnt   <= '0;
                     bitn  <= '0;
                     state <= rxd_s ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               RX_DATA: begin
                  if (bit_end) begin
                     cnt <= '0;
                     sh  <= {rxd_s, sh[BYTE_W-1:1]};
                     if (bitn == BIT_W'(BYTE_W - 1)) state <= RX_STOP;
                     else                            bitn  <= bitn + BIT_W'(1);
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               RX_STOP: begin
                  if (bit_end) begin
                     cnt       <= '0;
                     rx_valid  <= 1'b1;
                     frame_err <= ~rxd_s;
                     rx_data   <= sh;
                     state     <= rxd_s ? RX_IDLE : RX_WAIT_HIGH;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               RX_WAIT_HIGH: begin
                  if (rxd_s) state <= RX_IDLE;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/hostlink_port.sv
module hostlink_port
   import hostlink_pkg::*;
#(
   parameter int CLKS_PER_BIT = 64,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_isel,
   input  logic              mosi_rxd,
   input  logic              ss_rts_n,
   output logic              miso_txd,
   output logic              miso_oe,
   output logic              atn_cts_n,
   output logic              spi_mode,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              rx_ready,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_frame_err,
   output logic              wake
);
   localparam int PIN_W    = 3;
   localparam int PIN_SCLK = 0;
   localparam int PIN_DIN  = 1;
   localparam int PIN_SEL  = 2;

   if (CLKS_PER_BIT < 8 || (CLKS_PER_BIT % 2) != 0) begin : g_bad_rate
      $error("CLKS_PER_BIT must be even and at least 8");
   end

   logic [PIN_W-1:0]  pins_s;
   logic              ss_s, ss_d;
   logic              latched, mode_q;
   logic              spi_en, uart_en;
   logic              hold_full;
   logic [BYTE_W-1:0] hold_data;
   logic              spi_take, uart_take;
   logic              spi_miso, spi_active, spi_rx_valid;
   logic [BYTE_W-1:0] spi_rx_data;
   logic              uart_txd, uart_busy, uart_rx_valid, uart_ferr;
   logic [BYTE_W-1:0] uart_rx_data;

   hl_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ss_rts_n, mosi_rxd, sclk_isel}),
      .q     (pins_s)
   );

   assign ss_s = pins_s[PIN_SEL];

   // Mode strap: static pin, captured once in the first cycle out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched <= 1'b0;
         mode_q  <= 1'b0;
      end else if (!latched) begin
         latched <= 1'b1;
         mode_q  <= sclk_isel;
      end
   end

   assign spi_en   = latched & mode_q;
   assign uart_en  = latched & ~mode_q;
   assign spi_mode = mode_q;

   // One-byte transmit holding register shared by both engines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else if (tx_valid && tx_ready) begin
         hold_full <= 1'b1;
         hold_data <= tx_data;
      end else if (spi_take || uart_take) begin
         hold_full <= 1'b0;
      end
   end

   assign tx_ready  = latched & ~hold_full;
   assign uart_take = uart_en & hold_full & ~ss_s & ~uart_busy;

   hl_spi_slave i_spi (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (spi_en),
      .sclk_s    (pins_s[PIN_SCLK]),
      .mosi_s    (pins_s[PIN_DIN]),
      .ss_s      (ss_s),
      .hold_full (hold_full),
      .hold_data (hold_data),
      .rx_ready  (rx_ready),
      .take      (spi_take),
      .miso      (spi_miso),
      .active    (spi_active),
      .rx_valid  (spi_rx_valid),
      .rx_data   (spi_rx_data)
   );

   hl_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_utx (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (uart_en),
      .start (uart_take),
      .data  (hold_data),
      .txd   (uart_txd),
      .busy  (uart_busy)
   );

   hl_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_urx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (uart_en),
      .rxd_s     (pins_s[PIN_DIN]),
      .rx_valid  (uart_rx_valid),
      .frame_err (uart_ferr),
      .rx_data   (uart_rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ss_d <= 1'b1;
      else        ss_d <= ss_s;
   end
   assign wake = latched & ss_d & ~ss_s;

   always_comb begin
      if (!latched) begin
         miso_txd  = 1'b1;
         miso_oe   = 1'b0;
         atn_cts_n = 1'b1;
      end else if (mode_q) begin
         miso_txd  = spi_miso;
         miso_oe   = ~ss_s;
         atn_cts_n = ~(hold_full | rx_ready | spi_active);
      end else begin
         miso_txd  = uart_txd;
         miso_oe   = 1'b1;
         atn_cts_n = ~rx_ready;
      end
   end

   assign rx_valid     = spi_rx_valid | uart_rx_valid;
   assign rx_data      = mode_q ? spi_rx_data : uart_rx_data;
   assign rx_frame_err = uart_ferr;
endmodule

// File: rtl/hostlink_port_chk.sv
module hostlink_port_chk (
   input logic clk,
   input logic rst_n,
   input logic latched,
   input logic spi_mode,
   input logic ss_s,
   input logic miso_oe,
   input logic atn_cts_n,
   input logic wake,
   input logic tx_valid,
   input logic tx_ready,
   input logic rx_valid,
   input logic rx_frame_err
);
   assert_mode_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      latched |=> $stable(spi_mode));

   assert_idle_before_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !latched |-> (atn_cts_n && !miso_oe));

   assert_ferr_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_frame_err |-> (rx_valid && !spi_mode));

   assert_spi_rx_under_atn_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && spi_mode && rx_valid) |-> !atn_cts_n);

   assert_oe_async_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && !spi_mode) |-> miso_oe);

   assert_oe_spi_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && spi_mode && ss_s) |-> !miso_oe);

   assert_wake_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake);

   assert_hold_fills_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind hostlink_port hostlink_port_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .latched      (latched),
   .spi_mode     (spi_mode),
   .ss_s         (ss_s),
   .miso_oe      (miso_oe),
   .atn_cts_n    (atn_cts_n),
   .wake         (wake),
   .tx_valid     (tx_valid),
   .tx_ready     (tx_ready),
   .rx_valid     (rx_valid),
   .rx_frame_err (rx_frame_err)
);

// File: tb/test_hostlink_port.sv
`timescale 1ns/1ps
module test_hostlink_port;
   localparam int CPB      = 64;
   localparam int SPI_HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk_isel = 1'b1;
   logic       mosi_rxd = 1'b1;
   logic       ss_rts_n = 1'b1;
   logic       miso_txd, miso_oe, atn_cts_n, spi_mode;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic       rx_ready = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid, rx_frame_err, wake;

   int n_checks = 0;
   int n_errors = 0;
   int rx_cnt = 0;
   int wake_cnt = 0;
   logic [7:0] last_rx = 8'h00;
   logic       last_err = 1'b0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   hostlink_port #(.CLKS_PER_BIT(CPB)) i_hostlink_port (
      .clk(clk), .rst_n(rst_n), .sclk_isel(sclk_isel), .mosi_rxd(mosi_rxd),
      .ss_rts_n(ss_rts_n), .miso_txd(miso_txd), .miso_oe(miso_oe),
      .atn_cts_n(atn_cts_n), .spi_mode(spi_mode), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_ready(rx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
      .wake(wake)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_cnt++;
         last_rx  = rx_data;
         last_err = rx_frame_err;
      end
      if (wake) wake_cnt++;
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      rst_n = 1'b0;
      sclk_isel = strap;
      ss_rts_n = 1'b1;
      mosi_rxd = 1'b1;
      tx_valid = 1'b0;
      rx_ready = 1'b0;
      cycles(5);
      rst_n = 1'b1;
      cycles(6);
   endtask

   task automatic load_byte(input logic [7:0] d);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   // one byte, idle-high clock, host drives on fall and samples on rise
   task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
      for (int i = 7; i >= 0; i--) begin
         sclk_isel = 1'b0;
         mosi_rxd  = mo[i];
         cycles(SPI_HALF);
         sclk_isel = 1'b1;
         mi[i]     = miso_txd;
         cycles(SPI_HALF);
      end
   endtask

   task automatic spi_select(input logic lvl);
      @(negedge clk);
      ss_rts_n = lvl;
      cycles(8);
   endtask

   task automatic uart_send(input logic [7:0] b, input logic stop_v);
      @(negedge clk);
      mosi_rxd = 1'b0;
      cycles(CPB);
      for (int i = 0; i < 8; i++) begin
         mosi_rxd = b[i];
         cycles(CPB);
      end
      mosi_rxd = stop_v;
      cycles(CPB);
      mosi_rxd = 1'b1;
      cycles(2 * CPB);
   endtask

   task automatic uart_get(output logic [7:0] b, output logic start_v,
                           output logic stop_v, output logic seen);
      int t;
      t = 0;
      seen = 1'b0;
      b = 8'h00;
      start_v = 1'b1;
      stop_v = 1'b0;
      while (miso_txd && t < 3000) begin
         @(negedge clk);
         t++;
      end
      if (!miso_txd) begin
         seen = 1'b1;
         cycles(CPB / 2);
         start_v = miso_txd;
         for (int i = 0; i < 8; i++) begin
            cycles(CPB);
            b[i] = miso_txd;
         end
         cycles(CPB);
         stop_v = miso_txd;
         cycles(CPB / 2 + 4);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] got, got2, m, s, b;
      logic st, sp, seen;
      int rc, wc;
      void'($urandom(32'h5eed_0042));

      // synchronous mode
      do_reset(1'b1);
      check("R1", "spi_mode after high strap", spi_mode, 1);
      check("R2", "tx_ready after reset", tx_ready, 1);
      check("R2", "atn idle", atn_cts_n, 1);
      check("R2", "rx_valid idle", rx_cnt, 0);
      check("R11", "miso_oe deselected", miso_oe, 0);

      load_byte(8'h3C);
      cycles(1);
      check("R14", "tx_ready while held", tx_ready, 0);
      check("R9", "atn low with held byte", atn_cts_n, 0);

      rc = rx_cnt; wc = wake_cnt;
      spi_select(1'b0);
      check("R11", "miso_oe selected", miso_oe, 1);
      check("R12", "wake on select fall", wake_cnt - wc, 1);
      check("R14", "tx_ready after take", tx_ready, 1);
      spi_byte(8'hA5, got);
      spi_select(1'b1);
      check("R8", "host got slave byte", got, 8'h3C);
      check("R8", "rx count", rx_cnt - rc, 1);
      check("R8", "rx byte", last_rx, 8'hA5);
      check("R9", "atn high after exchange", atn_cts_n, 1);
      check("R11", "miso_oe after deselect", miso_oe, 0);

      // attention high: edges ignored
      rc = rx_cnt;
      spi_select(1'b0);
      spi_byte(8'h5A, got);
      check("R10", "atn stays high", atn_cts_n, 1);
      spi_select(1'b1);
      check("R10", "no rx when atn high", rx_cnt - rc, 0);

      // ready but nothing held: zero fill
      rx_ready = 1'b1;
      cycles(1);
      check("R9", "atn low on rx_ready", atn_cts_n, 0);
      rc = rx_cnt;
      spi_select(1'b0);
      spi_byte(8'hC3, got);
      spi_select(1'b1);
      check("R13", "zero fill", got, 8'h00);
      check("R8", "rx byte with fill", last_rx, 8'hC3);
      check("R8", "rx count with fill", rx_cnt - rc, 1);
      rx_ready = 1'b0;

      // two-byte burst, second byte loaded mid-select
      load_byte(8'h81);
      rc = rx_cnt;
      spi_select(1'b0);
      load_byte(8'h7E);
      spi_byte(8'h11, got);
      spi_byte(8'h22, got2);
      spi_select(1'b1);
      check("R8", "burst first", got, 8'h81);
      check("R8", "burst second", got2, 8'h7E);
      check("R8", "burst rx count", rx_cnt - rc, 2);
      check("R8", "burst last rx", last_rx, 8'h22);

      // random exchanges
      for (int k = 0; k < 8; k++) begin
         m = 8'($urandom);
         s = 8'($urandom);
         load_byte(s);
         spi_select(1'b0);
         spi_byte(m, got);
         spi_select(1'b1);
         check("R8", "random host got", got, s);
         check("R8", "random rx", last_rx, m);
      end

      // asynchronous mode
      do_reset(1'b0);
      check("R1", "spi_mode after low strap", spi_mode, 0);
      check("R2", "txd idle high", miso_txd, 1);
      check("R2", "cts idle", atn_cts_n, 1);
      check("R11", "oe in async", miso_oe, 1);
      rx_ready = 1'b1;
      cycles(1);
      check("R7", "cts low on ready", atn_cts_n, 0);
      rx_ready = 1'b0;
      cycles(1);
      check("R7", "cts high on not ready", atn_cts_n, 1);

      load_byte(8'hB4);
      seen = 1'b0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (!miso_txd) seen = 1'b1;
      end
      check("R4", "line held high with rts high", seen, 0);
      check("R4", "byte still held", tx_ready, 0);

      wc = wake_cnt;
      @(negedge clk);
      ss_rts_n = 1'b0;
      uart_get(b, st, sp, seen);
      check("R12", "wake on rts fall", wake_cnt - wc, 1);
      check("R3", "frame seen", seen, 1);
      check("R3", "start bit", st, 0);
      check("R3", "data", b, 8'hB4);
      check("R3", "stop bit", sp, 1);

      for (int k = 0; k < 4; k++) begin
         s = 8'($urandom);
         load_byte(s);
         uart_get(b, st, sp, seen);
         check("R3", "random data", b, s);
         check("R3", "random stop", sp, 1);
      end

      for (int k = 0; k < 4; k++) begin
         m = 8'($urandom);
         rc = rx_cnt;
         uart_send(m, 1'b1);
         check("R5", "rx count", rx_cnt - rc, 1);
         check("R5", "rx data", last_rx, m);
         check("R6", "no frame error", last_err, 0);
      end

      rc = rx_cnt;
      uart_send(8'h96, 1'b0);
      check("R6", "frame error flagged", last_err, 1);
      check("R6", "frame error count", rx_cnt - rc, 1);
      uart_send(8'h69, 1'b1);
      check("R5", "rx after error", last_rx, 8'h69);
      check("R6", "error cleared", last_err, 0);

      @(negedge clk);
      sclk_isel = 1'b1;
      cycles(20);
      check("R1", "mode ignores later strap", spi_mode, 0);
      check("R11", "oe still async", miso_oe, 1);

      finish_run();
   end
endmodule